// File: doc/BRIEF.md
# Lock-pair issue ordering gate

This block sits at the map stage of an out-of-order core. It keeps a load-locked / store-conditional pair in program order. It tracks every operation in an 8-slot issue queue: the kind of operation, its age tag and a per-slot wait bit. From these it reports which slots may issue. A load-locked takes part in store ordering exactly as a store does. A store-conditional is always inserted with its wait bit set, and it stays held until no older load-locked remains queued.

Once a store-conditional has been accepted, the gate stalls the map stage until the queue has fully drained. Younger loads and stores therefore cannot reach the queue and displace the locked line. On the fetch side, a lock bit opens when a load-locked is fetched and closes when any other memory reference is fetched. While the lock bit is open, every branch is predicted not taken, so the path between the pair cannot turn into a mispredicted one.

The scheduler is modelled as a grant vector, and a grant only takes effect on an eligible slot. A flush empties the queue, clears the lock bit and cancels a pending stall.

Top module: `lock_order_gate`

## Requirements
- R1: While reset is held, and on the cycle after it is released, all of the following are 0: `iq_valid`, `iq_wait`, `iq_count`, `map_stall` and `lock_open`. `bp_taken_out` follows `bp_taken_in`.
- R2: The kind codes are: 0 plain op, 1 load-locked, 2 store-conditional, 3 load, 4 store, 5 other memory op, 6 branch. An op is accepted when `map_valid` is high, `map_stall` is low and `flush` is low. An accepted op fills the lowest-numbered free slot, and its `iq_valid` bit reads 1 from the next cycle on.
- R3: A store-conditional always enters its slot with the wait bit at 1, whatever `map_stwait` says.
- R4: A slot is eligible exactly when it is valid and its wait bit is 0. A store-conditional's wait bit falls at the clock edge where the last older load-locked leaves. Older means a smaller age tag, taken as a modulo difference. It then reads 0 from the next cycle.
- R5: A non-store-conditional op enters with wait equal to `map_stwait`. Its wait bit stays at 1 while any older store, store-conditional or load-locked is queued, so a load-locked counts as a store.
- R6: After a store-conditional is accepted, `map_stall` is 1 on every cycle where `iq_count` is non-zero. On the first cycle `iq_count` reads 0, `map_stall` is 0 and a waiting op is accepted in that cycle.
- R7: `map_stall` is 1 while `iq_count` equals 8, and `iq_count` never exceeds 8.
- R8: A fetched load-locked sets `lock_open`. A fetched load, store, store-conditional or other memory op clears it. Plain ops, branches and cycles with `fetch_valid` low leave it unchanged.
- R9: While `lock_open` is 1, `bp_taken_out` is 0. Otherwise it equals `bp_taken_in`.
- R10: A flush clears every slot and wait bit, `lock_open` and the pending stall. An op presented during the flush cycle is not accepted.
- R11: A grant to a slot that is not eligible is ignored, and that slot stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush |
| fetch_valid | input | 1 | A fetched op is present |
| fetch_kind | input | 3 | Kind code of the fetched op |
| bp_taken_in | input | 1 | Direction from the predictor stub |
| bp_taken_out | output | 1 | Direction after the lock override |
| lock_open | output | 1 | Fetch-side lock bit |
| map_valid | input | 1 | Op present at the map stage |
| map_kind | input | 3 | Kind code of the map-stage op |
| map_age | input | AGE_W | Age tag of the map-stage op |
| map_stwait | input | 1 | Store-wait hint for non-store-conditional ops |
| map_stall | output | 1 | Map stage held |
| iq_grant | input | N | Scheduler stub issue grants, one per slot |
| iq_valid | output | N | Slot occupied |
| iq_wait | output | N | Per-slot wait bit |
| iq_eligible | output | N | Slot may issue |
| iq_count | output | clog2(N+1) | Number of occupied slots |

## Verification
The assertions check on every cycle that:
- a newly filled store-conditional slot carries its wait bit;
- a waiting slot never disappears except through a flush;
- an empty queue never stalls and a full one always does;
- a new store-conditional stalls the next cycle;
- the open lock bit forces not-taken;
- a flush leaves nothing behind.

Some behaviour only the bench scenarios can show. These are the exact cycle on which wait bits fall as older load-locked and store ops leave, the lowest-free-slot placement, and the lock bit's response to each fetched kind. They also include acceptance of the waiting op on the very cycle the drained queue reads empty.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;

    typedef enum logic [2:0] {
        K_ALU = 3'd0,
        K_LDL = 3'd1,
        K_STC = 3'd2,
        K_LD  = 3'd3,
        K_ST  = 3'd4,
        K_MEM = 3'd5,
        K_BR  = 3'd6
    } op_kind_e;

    typedef struct packed {
        logic     valid;
        logic     wait_b;
        op_kind_e kind;
    } iq_ent_t;

    function automatic logic is_memref(op_kind_e k);
        return (k == K_LDL) || (k == K_STC) || (k == K_LD) ||
               (k == K_ST)  || (k == K_MEM);
    endfunction

    // Store-class for ordering: a load-locked is ordered as a store.
    function automatic logic is_store_class(op_kind_e k);
        return (k == K_ST) || (k == K_LDL) || (k == K_STC);
    endfunction

    // Does a queued op of kind `other` hold back a waiting op of kind `waiter`?
    function automatic logic holds_back(op_kind_e waiter, op_kind_e other);
        if (waiter == K_STC)
            return other == K_LDL;
        return is_store_class(other);
    endfunction

endpackage

// File: rtl/lg_fetch_lock.sv
module lg_fetch_lock
    import lockgate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     fetch_valid,
    input  op_kind_e fetch_kind,
    input  logic     bp_taken_in,
    output logic     bp_taken_out,
    output logic     lock_open
);

    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst || flush)
            lock_q <= 1'b0;
        else if (fetch_valid) begin
            if (fetch_kind == K_LDL)
                lock_q <= 1'b1;
            else if (is_memref(fetch_kind))
                lock_q <= 1'b0;
        end
    end

    assign lock_open    = lock_q;
    assign bp_taken_out = bp_taken_in & ~lock_q;

endmodule

// File: rtl/lg_map_hold.sv
module lg_map_hold #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             map_valid,
    input  logic             map_is_stc,
    input  logic [CNT_W-1:0] occ,
    input  logic             full,
    output logic             map_stall,
    output logic             map_accept
);

    logic hold_q;
    logic empty;

    assign empty      = (occ == '0);
    assign map_stall  = (hold_q && !empty) || full;
    assign map_accept = map_valid && !map_stall && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush)
            hold_q <= 1'b0;
        else if (map_accept && map_is_stc)
            hold_q <= 1'b1;
        else if (empty)
            hold_q <= 1'b0;
    end

endmodule

// File: rtl/lg_iq_track.sv
module lg_iq_track
    import lockgate_pkg::*;
#(
    parameter  int N     = 8,
    parameter  int AGE_W = 6,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             alloc,
    input  op_kind_e         alloc_kind,
    input  logic [AGE_W-1:0] alloc_age,
    input  logic             alloc_stwait,
    input  logic [N-1:0]     grant,
    output logic [N-1:0]     slot_valid,
    output logic [N-1:0]     slot_wait,
    output logic [N-1:0]     slot_elig,
    output logic [CNT_W-1:0] occ,
    output logic             full
);

    iq_ent_t          ent_q [N];
    iq_ent_t          ent_d [N];
    logic [AGE_W-1:0] age_q [N];
    logic [N-1:0]     leave, surv, blk;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    function automatic logic is_older(logic [AGE_W-1:0] a, logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return d[AGE_W-1];
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign slot_valid[g] = ent_q[g].valid;
        assign slot_wait[g]  = ent_q[g].wait_b;
        assign slot_elig[g]  = ent_q[g].valid & ~ent_q[g].wait_b;
        assign leave[g]      = grant[g] & slot_elig[g];
        assign surv[g]       = ent_q[g].valid & ~leave[g];
    end

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_q[i].valid) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        occ = '0;
        for (int i = 0; i < N; i++)
            occ = occ + {{(CNT_W-1){1'b0}}, ent_q[i].valid};
    end
    assign full = (occ == CNT_W'(N));

    // Blockers are judged after this cycle's departures.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            blk[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && surv[j] && is_older(age_q[j], age_q[i]) &&
                    holds_back(ent_q[i].kind, ent_q[j].kind))
                    blk[i] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_d[i] = ent_q[i];
            if (leave[i])
                ent_d[i] = '0;
            else if (ent_q[i].valid && ent_q[i].wait_b && !blk[i])
                ent_d[i].wait_b = 1'b0;
        end
        if (alloc && free_found) begin
            ent_d[free_idx].valid  = 1'b1;
            ent_d[free_idx].kind   = alloc_kind;
            ent_d[free_idx].wait_b = (alloc_kind == K_STC) | alloc_stwait;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N; i++)
                ent_q[i] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                age_q[i] <= '0;
        end else if (alloc && free_found) begin
            age_q[free_idx] <= alloc_age;
        end
    end

endmodule

// File: rtl/lock_order_gate.sv
module lock_order_gate
    import lockgate_pkg::*;
#(
    parameter  int N     = 8,
    parameter  int AGE_W = 6,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fetch_valid,
    input  logic [2:0]       fetch_kind,
    input  logic             bp_taken_in,
    output logic             bp_taken_out,
    output logic             lock_open,
    input  logic             map_valid,
    input  logic [2:0]       map_kind,
    input  logic [AGE_W-1:0] map_age,
    input  logic             map_stwait,
    output logic             map_stall,
    input  logic [N-1:0]     iq_grant,
    output logic [N-1:0]     iq_valid,
    output logic [N-1:0]     iq_wait,
    output logic [N-1:0]     iq_eligible,
    output logic [CNT_W-1:0] iq_count
);

    op_kind_e m_kind;
    logic     map_accept;
    logic     iq_full;

    assign m_kind = op_kind_e'(map_kind);

    lg_fetch_lock u_lock (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .fetch_valid  (fetch_valid),
        .fetch_kind   (op_kind_e'(fetch_kind)),
        .bp_taken_in  (bp_taken_in),
        .bp_taken_out (bp_taken_out),
        .lock_open    (lock_open)
    );

    lg_map_hold #(.CNT_W(CNT_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .map_valid  (map_valid),
        .map_is_stc (m_kind == K_STC),
        .occ        (iq_count),
        .full       (iq_full),
        .map_stall  (map_stall),
        .map_accept (map_accept)
    );

    lg_iq_track #(.N(N), .AGE_W(AGE_W)) u_iq (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .alloc        (map_accept),
        .alloc_kind   (m_kind),
        .alloc_age    (map_age),
        .alloc_stwait (map_stwait),
        .grant        (iq_grant),
        .slot_valid   (iq_valid),
        .slot_wait    (iq_wait),
        .slot_elig    (iq_eligible),
        .occ          (iq_count),
        .full         (iq_full)
    );

endmodule

// File: rtl/lock_order_gate_chk.sv
module lock_order_gate_chk #(
    parameter int N     = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             map_accept,
    input logic [2:0]       map_kind,
    input logic             map_stall,
    input logic             lock_open,
    input logic             bp_taken_out,
    input logic [N-1:0]     iq_valid,
    input logic [N-1:0]     iq_wait,
    input logic [CNT_W-1:0] iq_count
);

    // R3: a slot filled by a store-conditional shows its wait bit
    a_r3_stc_enters_waiting: assert property (@(posedge clk) disable iff (rst)
        $past(map_accept && map_kind == 3'd2) |->
            ((iq_valid & ~$past(iq_valid) & ~iq_wait) == '0));

    // R6: an accepted store-conditional stalls the map stage next cycle
    a_r6_stc_stalls_next: assert property (@(posedge clk) disable iff (rst)
        $past(map_accept && map_kind == 3'd2) |-> map_stall);

    // R6: an empty queue never stalls
    a_r6_empty_releases: assert property (@(posedge clk) disable iff (rst)
        (iq_count == '0) |-> !map_stall);

    // R7: a full queue always stalls
    a_r7_full_stalls: assert property (@(posedge clk) disable iff (rst)
        (iq_count == CNT_W'(N)) |-> map_stall);

    // R7: occupancy bounded
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        iq_count <= CNT_W'(N));

    // R9: open lock bit forces fall-through
    a_r9_fallthrough: assert property (@(posedge clk) disable iff (rst)
        lock_open |-> !bp_taken_out);

    // R10: a flush leaves no slot and no lock
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> (iq_valid == '0 && !lock_open));

    // R11: a waiting slot only vanishes through a flush
    a_r11_waiting_stays: assert property (@(posedge clk) disable iff (rst)
        !$past(flush) |-> (($past(iq_valid & iq_wait) & ~iq_valid) == '0));

endmodule

bind lock_order_gate lock_order_gate_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .map_accept   (map_accept),
    .map_kind     (map_kind),
    .map_stall    (map_stall),
    .lock_open    (lock_open),
    .bp_taken_out (bp_taken_out),
    .iq_valid     (iq_valid),
    .iq_wait      (iq_wait),
    .iq_count     (iq_count)
);

// File: tb/sim_lock_order_gate.sv
module sim_lock_order_gate;

    localparam int N     = 8;
    localparam int AGE_W = 6;
    localparam int CNT_W = $clog2(N + 1);

    localparam logic [2:0] OP_ALU = 3'd0, OP_LDL = 3'd1, OP_STC = 3'd2,
                           OP_LD  = 3'd3, OP_ST  = 3'd4, OP_MEM = 3'd5,
                           OP_BR  = 3'd6;

    logic             clk = 1'b0;
    logic             rst, flush, fetch_valid, bp_taken_in, bp_taken_out, lock_open;
    logic [2:0]       fetch_kind, map_kind;
    logic             map_valid, map_stwait, map_stall;
    logic [AGE_W-1:0] map_age;
    logic [N-1:0]     iq_grant, iq_valid, iq_wait, iq_eligible;
    logic [CNT_W-1:0] iq_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lock_order_gate #(.N(N), .AGE_W(AGE_W)) u0 (.*);

    // fetch vector: valid, kind, bp in, expected bp out (before edge), expected lock (after edge)
    typedef struct packed {
        logic       fv;
        logic [2:0] kind;
        logic       bp;
        logic       exp_bp;
        logic       exp_lock;
    } fvec_t;

    localparam fvec_t FV [12] = '{
        '{1'b1, OP_LDL, 1'b1, 1'b1, 1'b1},
        '{1'b1, OP_BR,  1'b1, 1'b0, 1'b1},
        '{1'b1, OP_ALU, 1'b1, 1'b0, 1'b1},
        '{1'b0, OP_LD,  1'b1, 1'b0, 1'b1},
        '{1'b1, OP_LD,  1'b1, 1'b0, 1'b0},
        '{1'b1, OP_BR,  1'b1, 1'b1, 1'b0},
        '{1'b1, OP_LDL, 1'b0, 1'b0, 1'b1},
        '{1'b1, OP_MEM, 1'b1, 1'b0, 1'b0},
        '{1'b1, OP_LDL, 1'b1, 1'b1, 1'b1},
        '{1'b1, OP_STC, 1'b1, 1'b0, 1'b0},
        '{1'b1, OP_LDL, 1'b0, 1'b0, 1'b1},
        '{1'b1, OP_ST,  1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic v, input logic [2:0] k, input int age, input logic sw);
        map_valid  = v;
        map_kind   = k;
        map_age    = AGE_W'(age);
        map_stwait = sw;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        step();
        flush = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush = 1'b0; fetch_valid = 1'b0; fetch_kind = OP_ALU;
        bp_taken_in = 1'b1; iq_grant = '0;
        put(1'b0, OP_ALU, 0, 1'b0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 valid", 32'(iq_valid), 32'h0);
        chk("R1 wait", 32'(iq_wait), 32'h0);
        chk("R1 count", 32'(iq_count), 32'h0);
        chk("R1 stall", 32'(map_stall), 32'h0);
        chk("R1 lock", 32'(lock_open), 32'h0);
        chk("R1 bp pass", 32'(bp_taken_out), 32'h1);

        // Fetch-side lock and branch override walk (R8, R9)
        for (int k = 0; k < 12; k++) begin
            fetch_valid = FV[k].fv;
            fetch_kind  = FV[k].kind;
            bp_taken_in = FV[k].bp;
            #1;
            chk($sformatf("R9 bp step %0d", k), 32'(bp_taken_out), 32'(FV[k].exp_bp));
            step();
            chk($sformatf("R8 lock step %0d", k), 32'(lock_open), 32'(FV[k].exp_lock));
        end
        fetch_valid = 1'b1; fetch_kind = OP_LDL;
        step();
        fetch_valid = 1'b0;
        chk("R8 lock set", 32'(lock_open), 32'h1);
        do_flush();
        chk("R10 lock flushed", 32'(lock_open), 32'h0);

        // Load-locked then store-conditional (R2, R3, R4, R6, R11)
        put(1'b1, OP_LDL, 1, 1'b0);
        step();
        put(1'b1, OP_STC, 2, 1'b0);
        step();
        chk("R2 slots", 32'(iq_valid), 32'h03);
        chk("R3 stc wait", 32'(iq_wait), 32'h02);
        chk("R4 eligible", 32'(iq_eligible), 32'h01);
        put(1'b1, OP_ALU, 3, 1'b0);
        iq_grant = 8'h02;
        #1;
        chk("R6 stall after stc", 32'(map_stall), 32'h1);
        step();
        chk("R11 ineligible grant ignored", 32'(iq_valid), 32'h03);
        chk("R4 stc still waiting", 32'(iq_wait), 32'h02);
        iq_grant = 8'h01;
        step();
        chk("R4 stc released", 32'(iq_wait), 32'h00);
        chk("R4 stc eligible", 32'(iq_eligible), 32'h02);
        chk("R6 stall while nonempty", 32'(map_stall), 32'h1);
        iq_grant = 8'h02;
        step();
        iq_grant = '0;
        #1;
        chk("R6 release on empty", 32'(map_stall), 32'h0);
        step();
        chk("R6 younger accepted", 32'(iq_valid), 32'h01);
        put(1'b0, OP_ALU, 0, 1'b0);
        #1;
        chk("R6 hold cleared", 32'(map_stall), 32'h0);
        do_flush();

        // Load-locked ordered as a store (R5)
        put(1'b1, OP_ST, 10, 1'b0);  step();
        put(1'b1, OP_LD, 11, 1'b1);  step();
        put(1'b1, OP_LDL, 12, 1'b0); step();
        put(1'b1, OP_ST, 13, 1'b1);  step();
        put(1'b0, OP_ALU, 0, 1'b0);
        #1;
        chk("R5 waits", 32'(iq_wait), 32'h0A);
        chk("R5 eligible", 32'(iq_eligible), 32'h05);
        iq_grant = 8'h01;
        step();
        iq_grant = '0;
        chk("R5 load released", 32'(iq_wait), 32'h08);
        iq_grant = 8'h04;
        step();
        iq_grant = '0;
        chk("R5 ldl blocks store", 32'(iq_wait), 32'h00);
        do_flush();

        // Full queue (R7, R2)
        for (int k = 0; k < 8; k++) begin
            put(1'b1, OP_ALU, 20 + k, 1'b0);
            step();
        end
        put(1'b1, OP_ALU, 28, 1'b0);
        #1;
        chk("R7 count full", 32'(iq_count), 32'd8);
        chk("R7 stall full", 32'(map_stall), 32'h1);
        iq_grant = 8'h08;
        step();
        iq_grant = '0;
        chk("R7 ninth held", 32'(iq_valid), 32'hF7);
        chk("R7 stall off", 32'(map_stall), 32'h0);
        step();
        chk("R2 lowest free slot", 32'(iq_valid), 32'hFF);
        put(1'b0, OP_ALU, 0, 1'b0);
        do_flush();

        // Flush drops a pending stall (R10, R3)
        put(1'b1, OP_STC, 40, 1'b0);
        step();
        chk("R3 lone stc wait", 32'(iq_wait), 32'h01);
        put(1'b1, OP_ALU, 41, 1'b0);
        #1;
        chk("R6 stall on lone stc", 32'(map_stall), 32'h1);
        do_flush();
        chk("R10 slots flushed", 32'(iq_valid), 32'h00);
        chk("R10 stall dropped", 32'(map_stall), 32'h0);
        step();
        chk("R10 accepted after flush", 32'(iq_valid), 32'h01);
        put(1'b0, OP_ALU, 0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule